// File: doc/BRIEF.md
# MSI Doorbell to Interrupt-Line Bridge

This block is a message-signalled interrupt frame. It occupies a 4 KB register window on a simple single-cycle bus. A bus master such as a PCI root port writes a global interrupt ID into the doorbell register at offset 0x040. The frame turns that ID into a one-cycle pulse on one of its interrupt output wires. The wire index is the ID minus the first global ID the frame owns.

Two parameters place the frame in the global interrupt space. `BASE_SHARED` counts shared interrupts only, so shared interrupt 0 is global ID 32. `LINE_COUNT` sets the number of output wires; it may be 1 to 128 and defaults to 64. Elaboration stops if `LINE_COUNT` is outside that range, or if `BASE_SHARED + 32 + LINE_COUNT` exceeds 1020.

Software reads the description register at offset 0x008 to find where the frame sits in the ID space. It reads the interface identity register at offset 0xFCC. Bad accesses are dropped, read as zero and raise `acc_err` with the response.

Top module: `msi_line_bridge`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it rises, `irq_out`, `acc_err` and `rsp_valid` are all zero.
- R2: `req_ready` is always 1. `rsp_valid` is high in exactly the cycle after each cycle in which `req_valid` is high. `rsp_rdata` and `acc_err` are valid in that same cycle.
- R3: A read of offset 0x008 with `req_size`=2 returns `((BASE_SHARED+32) << 16) | LINE_COUNT`, with `acc_err` low.
- R4: A read of offset 0xFCC with `req_size`=2 returns 0x0510_0000. A read of any offset from 0xFD0 to 0xFFF with `req_size`=2 returns 0. Neither raises `acc_err`.
- R5: A write to offset 0x040 with `req_size` 1 (2 bytes) or 2 (4 bytes) takes ID = `req_wdata[9:0]`. Bits above bit 9 are ignored. If FIRST = BASE_SHARED+32 and FIRST <= ID < FIRST+LINE_COUNT, line ID-FIRST pulses high for one cycle. The pulse comes in the cycle after the request, and `acc_err` stays low.
- R6: A doorbell write whose ID is outside [FIRST, FIRST+LINE_COUNT) pulses no line and raises no error.
- R7: A write with `req_size` 0 (1 byte) or 3 (8 bytes) pulses no line and raises `acc_err` with its response.
- R8: A write to any offset other than 0x040 pulses no line and raises `acc_err`.
- R9: A read with `req_size` other than 2 returns 0 and raises `acc_err`.
- R10: A 4-byte read of any offset other than 0x008, 0xFCC and 0xFD0 to 0xFFF returns 0 and raises `acc_err`.
- R11: Doorbell writes in two consecutive cycles to the same line give two separate one-cycle pulses on that line, with one low cycle between them. A line is never high in two consecutive cycles.
- R12: A write response returns `rsp_rdata` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset in the window |
| req_size | input | 2 | log2 of the access size in bytes (0=1, 1=2, 2=4, 3=8) |
| req_wdata | input | 32 | Write data, little-endian lanes |
| req_ready | output | 1 | Always 1 |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data |
| acc_err | output | 1 | Previous request was a bad access |
| irq_out | output | LINE_COUNT | Interrupt pulse wires |

## Verification
The hardest situation to reach is a doorbell hitting a line whose pulse is already high. The design must then hold that trigger in a one-bit pending slot and replay it after a forced low cycle. The bench gets there by keeping the same in-range doorbell write on the bus for two consecutive cycles. It then watches the line go high, low, high, low. Around this, every ID from 0 to 1023 is swept through the doorbell. Every word offset in the window is read, and each size is tried on both reads and writes.

// File: rtl/msi_line_bridge.sv
module msi_line_bridge #(
  parameter int BASE_SHARED = 0,
  parameter int LINE_COUNT  = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [11:0]           req_addr,
  input  logic [1:0]            req_size,
  input  logic [31:0]           req_wdata,
  output logic                  req_ready,
  output logic                  rsp_valid,
  output logic [31:0]           rsp_rdata,
  output logic                  acc_err,
  output logic [LINE_COUNT-1:0] irq_out
);
  localparam int FIRST_ID = BASE_SHARED + 32;
  localparam int LAST_ID  = FIRST_ID + LINE_COUNT;
  localparam logic [31:0] DESC_VAL  = (32'(FIRST_ID) << 16) | 32'(LINE_COUNT);
  localparam logic [31:0] IDENT_VAL = 32'h51 << 20;

  generate
    if (LINE_COUNT < 1 || LINE_COUNT > 128) begin : g_bad_count
      $error("msi_line_bridge: LINE_COUNT must be 1..128");
    end
    if (BASE_SHARED < 0 || LAST_ID > 1020) begin : g_bad_base
      $error("msi_line_bridge: frame exceeds global ID 1020");
    end
  endgenerate

  assign req_ready = 1'b1;

  wire is_wr   = req_valid &  req_write;
  wire is_rd   = req_valid & ~req_write;
  wire wr_size = (req_size == 2'd1) || (req_size == 2'd2);
  wire bell    = req_addr == 12'h040;
  wire trig    = is_wr & bell & wr_size;

  wire [10:0] id     = {1'b0, req_wdata[9:0]};
  wire        in_rng = (id >= 11'(FIRST_ID)) && (id < 11'(LAST_ID));
  wire [10:0] offs   = id - 11'(FIRST_ID);

  logic [LINE_COUNT-1:0] hit, pend;
  assign hit = (trig && in_rng) ? (LINE_COUNT'(1) << offs) : '0;

  logic [31:0] rd_val;
  logic        rd_bad;
  always_comb begin
    rd_val = '0;
    rd_bad = 1'b0;
    if (req_size != 2'd2)            rd_bad = 1'b1;
    else if (req_addr == 12'h008)    rd_val = DESC_VAL;
    else if (req_addr == 12'hFCC)    rd_val = IDENT_VAL;
    else if (req_addr < 12'hFD0)     rd_bad = 1'b1;
  end

  wire wr_bad = ~bell | ~wr_size;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      acc_err   <= 1'b0;
      irq_out   <= '0;
      pend      <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= is_rd ? rd_val : '0;
      acc_err   <= (is_rd & rd_bad) | (is_wr & wr_bad);
      irq_out   <= (hit | pend) & ~irq_out;
      pend      <= (irq_out & (pend | hit)) | (~irq_out & pend & hit);
    end
  end
endmodule

module msi_line_bridge_chk #(
  parameter int BASE_SHARED = 0,
  parameter int LINE_COUNT  = 64
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input logic                  req_write,
  input logic [11:0]           req_addr,
  input logic [1:0]            req_size,
  input logic [31:0]           rsp_rdata,
  input logic                  rsp_valid,
  input logic                  acc_err,
  input logic [LINE_COUNT-1:0] irq_out
);
  localparam logic [31:0] DESC_VAL = (32'(BASE_SHARED + 32) << 16) | 32'(LINE_COUNT);

  AST_PULSE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out & $past(irq_out)) == '0); // R11
  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R2
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R2
  AST_BAD_WR_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && (req_size == 2'd0 || req_size == 2'd3)) |=> acc_err); // R7
  AST_WR_OFF_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr != 12'h040) |=> (acc_err && rsp_rdata == 32'd0)); // R8
  AST_DESC_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr == 12'h008 && req_size == 2'd2) |=> (rsp_rdata == DESC_VAL && !acc_err)); // R3
  AST_BAD_RD_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_size != 2'd2) |=> (acc_err && rsp_rdata == 32'd0)); // R9
endmodule

bind msi_line_bridge msi_line_bridge_chk #(.BASE_SHARED(BASE_SHARED), .LINE_COUNT(LINE_COUNT)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_size(req_size), .rsp_rdata(rsp_rdata),
  .rsp_valid(rsp_valid), .acc_err(acc_err), .irq_out(irq_out));

// File: tb/sim_msi_line_bridge.sv
module sim_msi_line_bridge;
  localparam int BASE = 3;
  localparam int CNT  = 8;
  localparam int FIRST = BASE + 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, acc_err;
  logic [31:0] rsp_rdata;
  logic [CNT-1:0] irq_out;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  msi_line_bridge #(.BASE_SHARED(BASE), .LINE_COUNT(CNT)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .acc_err(acc_err), .irq_out(irq_out));

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input bit wr, input logic [11:0] a, input logic [1:0] sz, input logic [31:0] d);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 rsp_valid", rsp_valid, 1);
    chk("R2 req_ready", req_ready, 1);
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    chk("R2 idle rsp_valid", rsp_valid, 0);
    chk("R11 pulse one cycle", irq_out, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 irq reset", irq_out, 0);
    chk("R1 err reset", acc_err, 0);
    chk("R1 rsp reset", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {irq_out, acc_err, rsp_valid}, 0);

    // R5 R6: sweep every ID, alternating size and junk upper bits
    for (int id = 0; id < 1024; id++) begin
      logic [31:0] d;
      longint exp;
      d = {22'(id * 7919), 10'(id)};
      exp = (id >= FIRST && id < FIRST + CNT) ? (longint'(1) << (id - FIRST)) : 0;
      issue(1'b1, 12'h040, (id % 2) ? 2'd1 : 2'd2, d);
      chk(exp != 0 ? "R5 line pulse" : "R6 out of range", irq_out, exp);
      chk("R5 no err", acc_err, 0);
      chk("R12 write rdata", rsp_rdata, 0);
      idle_cycle();
    end

    // R7: bad write sizes with in-range ID
    for (int s = 0; s < 4; s += 3) begin
      issue(1'b1, 12'h040, 2'(s), 32'(FIRST + 2));
      chk("R7 no pulse", irq_out, 0);
      chk("R7 err", acc_err, 1);
      idle_cycle();
    end

    // R8: writes elsewhere
    for (int a = 0; a < 4096; a += 4) begin
      if (a == 12'h040) continue;
      issue(1'b1, 12'(a), 2'd2, 32'(FIRST));
      chk("R8 no pulse", irq_out, 0);
      chk("R8 err", acc_err, 1);
      @(negedge clk);
    end

    // R3 R4 R10: read every word offset
    for (int a = 0; a < 4096; a += 4) begin
      longint ev;
      longint ee;
      ev = 0; ee = 1;
      if (a == 'h008) begin ev = (longint'(FIRST) << 16) | CNT; ee = 0; end
      else if (a == 'hFCC) begin ev = 32'h0510_0000; ee = 0; end
      else if (a >= 'hFD0) ee = 0;
      issue(1'b0, 12'(a), 2'd2, 32'hFFFF_FFFF);
      chk(a == 'h008 ? "R3 desc" : (ee == 0 ? "R4 ident" : "R10 undefined"), rsp_rdata, ev);
      chk(ee == 0 ? "R4 no err" : "R10 err", acc_err, ee);
    end

    // R9: bad read sizes
    for (int s = 0; s < 4; s++) begin
      if (s == 2) continue;
      issue(1'b0, 12'h008, 2'(s), 32'd0);
      chk("R9 zero", rsp_rdata, 0);
      chk("R9 err", acc_err, 1);
    end

    // R11: back-to-back doorbells to each line
    for (int l = 0; l < CNT; l++) begin
      req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h040; req_size = 2'd2;
      req_wdata = 32'(FIRST + l);
      @(negedge clk);
      chk("R11 first pulse", irq_out, longint'(1) << l);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R11 gap", irq_out, 0);
      @(negedge clk);
      chk("R11 second pulse", irq_out, longint'(1) << l);
      @(negedge clk);
      chk("R11 end", irq_out, 0);
    end

    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 150000 && !done; i++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule